// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit accumulator datapath of a small byte-wide processor. Every clock edge on which `op_valid` is high, the block decodes `op_code` and updates the accumulator and a four-bit status word in one step. The operations are:

- add a register value or an immediate, supplied on `operand`, to the accumulator;
- load a 4-bit constant carried in the low nibble of the operation code (a constant of zero clears the accumulator);
- invert every accumulator bit;
- shift the accumulator left or right by one or by four places.

Each operation has its own rule for which flags it computes, forces or leaves alone.

Both the accumulator and the status word are registers inside the block. Surrounding logic handles fetch, the register file and branching. It presents one operation per cycle and reads the new accumulator and flags on the following cycle. Operation codes outside the supported set are ignored, so the block can sit on a shared instruction bus.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is set to 0x00 and all status bits are set to 0.
- R2: Operation codes 0xC0 to 0xCF (register add) and 0x24 (immediate add) replace the accumulator with (accumulator + `operand`) mod 256. The carry flag receives the carry out of bit 7.
- R3: On an add, the overflow flag is set exactly when the carry into bit 7 differs from the carry out of bit 7. This is two's-complement overflow.
- R4: For every operation that computes flags (adds, shifts, complement), the zero flag is 1 exactly when all 8 result bits are 0.
- R5: For adds, left shifts and complement, the sign flag is the inverse of result bit 7. It is 1 for a zero or positive result.
- R6: Code 0x13 shifts left by one and 0x15 shifts left by four. Both fill with zeros, discard the bits shifted out, and clear overflow and carry.
- R7: Code 0x12 shifts right by one and 0x14 shifts right by four. Both fill with zeros, clear overflow and carry, and force the sign flag to 1.
- R8: Code 0x18 inverts all accumulator bits and clears overflow and carry.
- R9: Codes 0x70 to 0x7F load the low nibble of the code, zero-extended, into the accumulator. 0x70 therefore clears it. These codes leave all four flags unchanged.
- R10: When `op_valid` is low, or the code is not listed in R2 or R6 to R9, the accumulator and the flags keep their values.
- R11: The `status` port carries sign in bit 0, carry in bit 1, zero in bit 2 and overflow in bit 3.
- R12: The results of an operation presented at a clock edge appear on `acc` and `status` after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 8 | Operation code; its low nibble is the short constant |
| operand | input | 8 | Register or immediate byte for adds |
| acc | output | 8 | Accumulator value |
| status | output | 4 | Flags: {overflow, zero, carry, sign} |

## Verification
The hardest state to reach is an add whose result is zero while carry, overflow and zero are all set together. Only two negative operands of 0x80 produce it. The stimulus loads a small constant, then adds values chosen so that the accumulator passes through 0x80 before the second 0x80 is added. Later vectors reach a zero result through a left shift of 0x80 and through a wrap from 0xFF. Together these show that shifted-out bits never reach the carry flag. A chain of load-constant operations between flag-setting ones shows that the flags survive operations that must not touch them.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OPC_W    = 8;
    localparam int SH_SMALL = 1;
    localparam int SH_BIG   = 4;

    // Operation codes the decoder recognises
    localparam logic [OPC_W-1:0] OPC_SHL1 = 8'h13;
    localparam logic [OPC_W-1:0] OPC_SHL4 = 8'h15;
    localparam logic [OPC_W-1:0] OPC_SHR1 = 8'h12;
    localparam logic [OPC_W-1:0] OPC_SHR4 = 8'h14;
    localparam logic [OPC_W-1:0] OPC_INV  = 8'h18;
    localparam logic [OPC_W-1:0] OPC_ADDI = 8'h24;
    localparam logic [3:0]       NIB_LDK  = 4'h7;
    localparam logic [3:0]       NIB_ADDR = 4'hC;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADD,
        K_LDK,
        K_SHL,
        K_SHR,
        K_INV
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       wide;   // shift by SH_BIG instead of SH_SMALL
        logic [3:0] konst;
    } alu_ctl_t;

    // Bit order of this struct is the status port layout
    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
        logic sign;
    } flags_t;

    function automatic alu_ctl_t decode_op(input logic vld, input logic [OPC_W-1:0] opc);
        alu_ctl_t c;
        c.kind  = K_NONE;
        c.wide  = 1'b0;
        c.konst = opc[3:0];
        if (vld) begin
            if (opc[7:4] == NIB_LDK || opc[7:4] == NIB_ADDR) begin
                c.kind = (opc[7:4] == NIB_LDK) ? K_LDK : K_ADD;
            end else begin
                case (opc)
                    OPC_ADDI: c.kind = K_ADD;
                    OPC_SHL1: c.kind = K_SHL;
                    OPC_SHL4: begin c.kind = K_SHL; c.wide = 1'b1; end
                    OPC_SHR1: c.kind = K_SHR;
                    OPC_SHR4: begin c.kind = K_SHR; c.wide = 1'b1; end
                    OPC_INV:  c.kind = K_INV;
                    default:  c.kind = K_NONE;
                endcase
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    output alu_ctl_t         ctl
);
    always_comb ctl = decode_op(op_valid, op_code);
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_ctl_t          ctl,
    input  logic [DATA_W-1:0] acc_q,
    input  flags_t            flg_q,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_d,
    output flags_t            flg_d
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum;
    logic              c_out;
    logic              c_into_msb;
    logic [DATA_W-1:0] res;

    always_comb begin
        {c_out, sum} = {1'b0, acc_q} + {1'b0, operand};
        c_into_msb   = acc_q[MSB] ^ operand[MSB] ^ sum[MSB];
    end

    always_comb begin
        res   = acc_q;
        acc_d = acc_q;
        flg_d = flg_q;
        case (ctl.kind)
            K_ADD: begin
                res         = sum;
                acc_d       = sum;
                flg_d.ovf   = c_out ^ c_into_msb;
                flg_d.carry = c_out;
                flg_d.zero  = (sum == '0);
                flg_d.sign  = ~sum[MSB];
            end
            K_LDK: begin
                acc_d = DATA_W'(ctl.konst);
            end
            K_SHL, K_SHR, K_INV: begin
                if (ctl.kind == K_SHL)
                    res = ctl.wide ? (acc_q << SH_BIG) : (acc_q << SH_SMALL);
                else if (ctl.kind == K_SHR)
                    res = ctl.wide ? (acc_q >> SH_BIG) : (acc_q >> SH_SMALL);
                else
                    res = ~acc_q;
                acc_d       = res;
                flg_d.ovf   = 1'b0;
                flg_d.carry = 1'b0;
                flg_d.zero  = (res == '0);
                flg_d.sign  = (ctl.kind == K_SHR) ? 1'b1 : ~res[MSB];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] acc_d,
    input  flags_t            flg_d,
    output logic [DATA_W-1:0] acc_q,
    output flags_t            flg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            flg_q <= '0;
        end else begin
            acc_q <= acc_d;
            flg_q <= flg_d;
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc,
    output logic [3:0]        status
);
    alu_ctl_t          ctl;
    logic [DATA_W-1:0] acc_q, acc_d;
    flags_t            flg_q, flg_d;

    acc_alu_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctl      (ctl)
    );

    acc_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .ctl     (ctl),
        .acc_q   (acc_q),
        .flg_q   (flg_q),
        .operand (operand),
        .acc_d   (acc_d),
        .flg_d   (flg_d)
    );

    acc_alu_state #(.DATA_W(DATA_W)) u_state (
        .clk   (clk),
        .rst   (rst),
        .acc_d (acc_d),
        .flg_d (flg_d),
        .acc_q (acc_q),
        .flg_q (flg_q)
    );

    assign acc    = acc_q;
    assign status = flg_q;   // R11: {ovf, zero, carry, sign}
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [7:0]        op_code,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc,
    input logic [3:0]        status
);
    logic is_add, is_shr, is_clr_oc, is_ldk, is_known;
    assign is_add    = op_valid && (op_code[7:4] == 4'hC || op_code == 8'h24);
    assign is_shr    = op_valid && (op_code == 8'h12 || op_code == 8'h14);
    assign is_clr_oc = op_valid && (op_code == 8'h12 || op_code == 8'h14 ||
                                    op_code == 8'h13 || op_code == 8'h15 || op_code == 8'h18);
    assign is_ldk    = op_valid && (op_code[7:4] == 4'h7);
    assign is_known  = is_add || is_clr_oc || is_ldk;

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        is_add |=> {status[1], acc} == {1'b0, $past(acc)} + {1'b0, $past(operand)}); // R2

    AST_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
        is_add |=> status[3] == (($past(acc[DATA_W-1]) == $past(operand[DATA_W-1])) &&
                                 (acc[DATA_W-1] != $past(acc[DATA_W-1])))); // R3

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_add || is_clr_oc) |=> status[2] == (acc == '0)); // R4

    AST_SHIFT_OC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        is_clr_oc |=> (status[3] == 1'b0) && (status[1] == 1'b0)); // R6

    AST_SHR_SIGN: assert property (@(posedge clk) disable iff (rst)
        is_shr |=> status[0]); // R7

    AST_LDK_FLAGS: assert property (@(posedge clk) disable iff (rst)
        is_ldk |=> $stable(status) && acc == DATA_W'($past(op_code[3:0]))); // R9

    AST_IGNORED_OP: assert property (@(posedge clk) disable iff (rst)
        !is_known |=> $stable(acc) && $stable(status)); // R10
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_acc_alu_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc      (acc),
    .status   (status)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc;
    logic [3:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .operand  (operand),
        .acc      (acc),
        .status   (status)
    );

    // {op_code, operand, expected acc, expected status{O,Z,C,S}}, applied in order
    localparam int NV = 21;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {8'h75, 8'h00, 8'h05, 4'h0},  // load 5, flags kept
        {8'h24, 8'h03, 8'h08, 4'h1},  // imm add
        {8'hC3, 8'h78, 8'h80, 4'h8},  // signed overflow, no carry
        {8'hC0, 8'h80, 8'h00, 4'hF},  // 80+80: all flags
        {8'h70, 8'h00, 8'h00, 4'hF},  // clear keeps flags
        {8'h7F, 8'h00, 8'h0F, 4'hF},  // load F
        {8'h15, 8'h00, 8'hF0, 4'h0},  // shl 4
        {8'h13, 8'h00, 8'hE0, 4'h0},  // shl 1
        {8'h14, 8'h00, 8'h0E, 4'h1},  // shr 4
        {8'h12, 8'h00, 8'h07, 4'h1},  // shr 1
        {8'h18, 8'h00, 8'hF8, 4'h0},  // invert
        {8'h24, 8'h08, 8'h00, 4'h7},  // -8+8: carry, zero, no ovf
        {8'h2B, 8'h55, 8'h00, 4'h7},  // unknown code ignored
        {8'h18, 8'h00, 8'hFF, 4'h0},  // invert 0
        {8'h24, 8'h01, 8'h00, 4'h7},  // wrap from FF
        {8'h12, 8'h00, 8'h00, 4'h5},  // shr of zero: Z and S
        {8'hCF, 8'h7F, 8'h7F, 4'h1},  // reg add
        {8'h24, 8'h01, 8'h80, 4'h8},  // 7F+1 overflow
        {8'h13, 8'h00, 8'h00, 4'h5},  // shl of 80: bit lost, no carry
        {8'h79, 8'h00, 8'h09, 4'h5},  // load 9, flags kept
        {8'h13, 8'h00, 8'h12, 4'h1}   // shl 1
    };

    function automatic string tag_of(input logic [7:0] opc);
        if (opc[7:4] == 4'hC || opc == 8'h24) return "R2/R3/R4/R5";
        if (opc == 8'h13 || opc == 8'h15)     return "R6/R4/R5";
        if (opc == 8'h12 || opc == 8'h14)     return "R7/R4";
        if (opc == 8'h18)                     return "R8/R4/R5";
        if (opc[7:4] == 4'h7)                 return "R9";
        return "R10";
    endfunction

    // Status layout per R11: bit3 ovf, bit2 zero, bit1 carry, bit0 sign
    task automatic check(input logic [7:0] e_acc, input logic [3:0] e_st, input string tag);
        n_chk++;
        if (acc !== e_acc || status !== e_st) begin
            n_bad++;
            $display("FAIL %s R11: acc=%02h status=%01h expected acc=%02h status=%01h",
                     tag, acc, status, e_acc, e_st);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] opc, input logic [7:0] opd);
        op_valid = v;
        op_code  = opc;
        operand  = opd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        @(posedge clk);
        @(posedge clk);
        #1;
        check(8'h00, 4'h0, "R1 reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][27:20], VEC[i][19:12]);
            check(VEC[i][11:4], VEC[i][3:0], tag_of(VEC[i][27:20]));
        end

        // R10: a valid code with op_valid low does nothing
        step(1'b0, 8'h24, 8'h10);
        check(8'h12, 4'h1, "R10 op_valid low");

        // R12: nothing shows before the edge, result right after it
        op_valid = 1'b1;
        op_code  = 8'h73;
        operand  = 8'h00;
        #1;
        check(8'h12, 4'h1, "R12 before edge");
        @(posedge clk);
        #1;
        check(8'h03, 4'h1, "R12 after edge");

        // R1: reset in mid-run, with an add presented at the same edge
        op_code = 8'h24;
        operand = 8'h40;
        rst     = 1'b1;
        @(posedge clk);
        #1;
        check(8'h00, 4'h0, "R1 mid-run reset");
        rst = 1'b0;
        step(1'b1, 8'h24, 8'h40);
        check(8'h40, 4'h1, "R2 after reset");
        step(1'b0, 8'h00, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule